// File: doc/BRIEF.md
# Port Pin Edge Interrupt Unit

This block serves one I/O port of eight input pins. Each pin has its own two-bit mode that selects which transitions of that pin count as events: none, low-to-high, high-to-low, or both. When a pin produces a qualifying transition, the matching bit of a sticky status byte is set. One interrupt line for the whole port stays high while any status bit is set.

Software services the port by reading the status byte. The read strobe is given in the same cycle the byte is sampled. On that clock edge every status bit clears, apart from bits whose pin has a new qualifying transition in that same cycle. A transition that arrives during a read is therefore never lost. Pin inputs are expected to be synchronised to the clock already.

Top module: `port_edge_irq`

## Requirements
- R1: While rst_ni is low and directly after its release, status_o is 8'h00 and irq_o is low.
- R2: A transition of pin i is detected by comparing its level at a rising clock edge with its level at the previous rising clock edge. The first clock edge after reset only takes the baseline, so a pin held high through reset causes no event.
- R3: Pin i's mode is mode_i[2i+1:2i]. With mode 2'b01, a low-to-high transition sets status_o[i], and this is visible after the clock edge that sees the new level. A high-to-low transition has no effect.
- R4: With mode 2'b10, a high-to-low transition sets status_o[i], and a low-to-high transition has no effect.
- R5: With mode 2'b11, transitions in both directions set status_o[i].
- R6: With mode 2'b00, transitions of pin i never set status_o[i].
- R7: irq_o is high in exactly those cycles in which status_o is non-zero.
- R8: A set status bit stays set, across further transitions, until a read clears it.
- R9: When rd_i is high at a clock edge, every status bit clears at that edge, except bits whose pin has a qualifying transition at the same edge. Those bits remain set.
- R10: Pins are handled independently. Transitions on several pins in the same cycle set all of the corresponding bits, each under its own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Synchronised pin levels |
| mode_i | input | 16 | Per-pin edge mode, two bits per pin |
| rd_i | input | 1 | Status read strobe, clears on the edge it is sampled |
| status_o | output | 8 | Sticky per-pin event flags |
| irq_o | output | 1 | Port interrupt request |

## Verification
The hardest case to reach is a read that coincides with a new transition. It needs a status bit that is already set, plus a different pin, or the same pin, changing level in exactly the cycle rd_i is high. The bench first arms one bit. It then raises rd_i and toggles a second pin at the same falling clock edge. It checks the byte returned by the read, and then checks that only the new bit is left afterwards. A second case repeats the collision on the pin that is already set. The baseline after reset is reached by holding a pin high through reset in any-edge mode.

// File: rtl/port_edge_irq_pkg.sv
package port_edge_irq_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/pin_sampler.sv
module pin_sampler #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] rise_o,
  output logic [N_PINS-1:0] fall_o
);
  logic [N_PINS-1:0] prev_q;
  logic              primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_i;
      primed_q <= 1'b1;
    end
  end

  // no transitions until a baseline has been captured
  assign rise_o = primed_q ? (pin_i & ~prev_q) : '0;
  assign fall_o = primed_q ? (~pin_i & prev_q) : '0;
endmodule

// File: rtl/edge_select.sv
module edge_select
  import port_edge_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  localparam int unsigned CFG_W = N_PINS * MODE_W
) (
  input  logic [N_PINS-1:0] rise_i,
  input  logic [N_PINS-1:0] fall_i,
  input  logic [CFG_W-1:0]  mode_i,
  output logic [N_PINS-1:0] event_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    edge_mode_e mode;
    assign mode = edge_mode_e'(mode_i[g*MODE_W +: MODE_W]);

    always_comb begin
      unique case (mode)
        EDGE_RISE: event_o[g] = rise_i[g];
        EDGE_FALL: event_o[g] = fall_i[g];
        EDGE_BOTH: event_o[g] = rise_i[g] | fall_i[g];
        default:   event_o[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/status_reg.sv
module status_reg #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] event_i,
  input  logic              rd_i,
  output logic [N_PINS-1:0] status_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] status_q, status_d;

  // new events win over the clear on read
  assign status_d = (rd_i ? '0 : status_q) | event_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;
endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
  import port_edge_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  localparam int unsigned CFG_W = N_PINS * MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [CFG_W-1:0]  mode_i,
  input  logic              rd_i,
  output logic [N_PINS-1:0] status_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] rise, fall, evt;

  pin_sampler #(.N_PINS(N_PINS)) sampler_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  edge_select #(.N_PINS(N_PINS)) select_i (
    .rise_i  (rise),
    .fall_i  (fall),
    .mode_i  (mode_i),
    .event_o (evt)
  );

  status_reg #(.N_PINS(N_PINS)) status_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (evt),
    .rd_i     (rd_i),
    .status_o (status_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/port_edge_irq_chk.sv
module port_edge_irq_chk #(
  parameter int unsigned N_PINS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_PINS-1:0]     pin_i,
  input logic [2*N_PINS-1:0]   mode_i,
  input logic                  rd_i,
  input logic [N_PINS-1:0]     status_o,
  input logic                  irq_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R7
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o != '0));

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && rd_i && pin_i == $past(pin_i)) |=> status_o == '0);

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    // R6
    off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[2*g +: 2] == 2'b00) |=> !$rose(status_o[g]));
    // R3
    rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd1 && mode_i[2*g +: 2] == 2'b01 && pin_i[g] && !$past(pin_i[g]))
      |=> status_o[g]);
    // R4
    fall_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd1 && mode_i[2*g +: 2] == 2'b10 && !pin_i[g] && $past(pin_i[g]))
      |=> status_o[g]);
  end
endmodule

bind port_edge_irq port_edge_irq_chk #(.N_PINS(N_PINS)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pin_i    (pin_i),
  .mode_i   (mode_i),
  .rd_i     (rd_i),
  .status_o (status_o),
  .irq_o    (irq_o)
);

// File: tb/port_edge_irq_tb_top.sv
module port_edge_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin = '0;
  logic [15:0] mode = '0;
  logic        rd = 1'b0;
  logic [7:0]  status;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  port_edge_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .mode_i(mode),
    .rd_i(rd), .status_o(status), .irq_o(irq)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(int p, logic [1:0] m);
    mode[2*p +: 2] = m;
  endtask

  task automatic do_read(logic [7:0] exp, string req);
    rd = 1'b1;
    chk(req, status, exp);
    step();
    rd = 1'b0;
  endtask

  task automatic reset_dut(logic [7:0] pins_during);
    rst_n = 1'b0;
    pin = pins_during;
    rd = 1'b0;
    step(2);
    chk("R1 status in reset", status, 8'h00);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R1 status after release", status, 8'h00);
  endtask

  task automatic t_baseline();
    mode = '1;
    reset_dut(8'h81);
    step(3);
    chk("R2 no event from reset baseline", status, 8'h00);
    chk("R7 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rise();
    mode = '0; reset_dut(8'h00);
    set_mode(0, 2'b01);
    pin[0] = 1'b1; step();
    chk("R3 rising sets bit0", status, 8'h01);
    chk("R7 irq high", {7'd0, irq}, 8'h01);
    do_read(8'h01, "R9 read value");
    chk("R9 cleared after read", status, 8'h00);
    chk("R7 irq low after read", {7'd0, irq}, 8'h00);
    pin[0] = 1'b0; step(2);
    chk("R3 falling ignored in rise mode", status, 8'h00);
  endtask

  task automatic t_fall();
    mode = '0; reset_dut(8'h00);
    set_mode(3, 2'b10);
    pin[3] = 1'b1; step(2);
    chk("R4 rising ignored in fall mode", status, 8'h00);
    pin[3] = 1'b0; step();
    chk("R4 falling sets bit3", status, 8'h08);
    do_read(8'h08, "R4 read");
  endtask

  task automatic t_both();
    mode = '0; reset_dut(8'h00);
    set_mode(5, 2'b11);
    pin[5] = 1'b1; step();
    chk("R5 rise in both mode", status, 8'h20);
    do_read(8'h20, "R5 read");
    pin[5] = 1'b0; step();
    chk("R5 fall in both mode", status, 8'h20);
    do_read(8'h20, "R5 read 2");
  endtask

  task automatic t_off();
    mode = '1; set_mode(6, 2'b00);
    reset_dut(8'h00);
    pin[6] = 1'b1; step();
    pin[6] = 1'b0; step(2);
    chk("R6 disabled pin ignored", status, 8'h00);
  endtask

  task automatic t_multi();
    mode = '0; reset_dut(8'h00);
    set_mode(1, 2'b01); set_mode(2, 2'b10); set_mode(4, 2'b11); set_mode(7, 2'b01);
    pin = 8'h04; step();
    chk("R10 only fall-mode pin2 idle", status, 8'h00);
    pin = 8'h92; step();   // pin1 rise, pin2 fall, pin4 rise, pin7 rise
    chk("R10 simultaneous events", status, 8'h96);
    pin = 8'h80; step(3);  // pin1 fall (rise-only), pin4 fall
    chk("R8 sticky across further edges", status, 8'h96);
    do_read(8'h96, "R10 read");
    chk("R9 all cleared", status, 8'h00);
  endtask

  task automatic t_collide();
    mode = '0; reset_dut(8'h00);
    set_mode(1, 2'b01); set_mode(2, 2'b01);
    pin[1] = 1'b1; step();
    chk("R3 arm bit1", status, 8'h02);
    pin[2] = 1'b1;
    do_read(8'h02, "R9 read during new edge");
    chk("R9 new edge survives read", status, 8'h04);
    chk("R7 irq stays high", {7'd0, irq}, 8'h01);
    set_mode(2, 2'b11);
    pin[2] = 1'b0;
    do_read(8'h04, "R9 same pin read");
    chk("R9 same-pin edge survives read", status, 8'h04);
    do_read(8'h04, "R9 final read");
    chk("R9 finally cleared", status, 8'h00);
  endtask

  initial begin
    t_baseline();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_multi();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule